// File: doc/BRIEF.md
# Backplane FEC Frame Encoder

This block sits behind a 64B/66B coding layer and turns its stream of 66-bit blocks into forward error correction frames for a serial backplane link. Each incoming block loses one of its two sync header bits. The remaining header bit is the transcode bit: 0 marks a control block and 1 marks a data block. Thirty-two such 65-bit words make 2080 data bits. A 32-bit remainder of a shortened cyclic code is appended to them. The whole 2112-bit frame is then XORed with a pseudo-noise sequence that restarts at every frame.

Because 32 blocks of 66 bits also occupy 2112 bit times, the frame keeps the line rate of the unencoded stream. Blocks enter on a valid/ready handshake. Bits leave one per clock with a qualifier, a pulse that marks the first bit of each frame, and a flag that marks the transcode bit of any block whose sync header was illegal.

Top module: `fec_frame_encoder`

## Requirements
- R1: While reset is held, and after it until a block arrives, `tx_valid`, `tx_sof` and `tx_hdr_err` are 0 and `blk_ready` is 1.
- R2: Input bit `blk_data[1]` is the second sync header bit. It is sent as the transcode bit, and it is the first bit of that block's 65-bit slot in the frame. Blocks occupy their slots in the order they were accepted.
- R3: After the transcode bit, the 64 payload bits are sent from `blk_data[2]` up to `blk_data[65]`, one per bit time.
- R4: Bit positions 2080 to 2111 of each frame hold the remainder of dividing the 2080 unscrambled data bits, multiplied by x^32, by the generator x^32+x^23+x^21+x^11+x^2+1. The first data bit is the highest-degree term. The highest-degree remainder bit is sent first. The division starts from zero in every frame.
- R5: Every sent bit is XORed with a pseudo-noise bit. The generator keeps 58 bits of state `s`. Each bit time it produces `p = s[57]^s[38]` and shifts `s` left, taking `p` in at bit 0. At the first bit of every frame `s` is loaded with 58'h3C3C3C3C3C3C3C3.
- R6: When blocks are always offered, one bit leaves on every clock, consecutive frame starts are exactly 2112 clocks apart, and the 32 parity bits are never interrupted.
- R7: `tx_sof` is 1 together with the first bit of every frame and at no other time.
- R8: A block whose sync header is 00 or 11 is still sent, with `blk_data[1]` as its transcode bit. `tx_hdr_err` is 1 together with that transcode bit and is 0 for all other bits.
- R9: A block is taken only in a cycle where `blk_valid` and `blk_ready` are both 1. If no block is waiting in the data part of a frame, `tx_valid` drops to 0. Output resumes when a block arrives, with no bit lost or repeated.
- R10: When the encoder is idle, the first bit of a block accepted at a clock edge appears on the outputs after the second edge that follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| blk_valid | input | 1 | A 66-bit block is offered |
| blk_ready | output | 1 | The encoder can take the offered block |
| blk_data | input | 66 | Block: [1:0] sync header (bit 0 first), [65:2] payload |
| tx_valid | output | 1 | `tx_bit` carries a frame bit |
| tx_bit | output | 1 | Scrambled serial frame bit |
| tx_sof | output | 1 | First bit of a frame |
| tx_hdr_err | output | 1 | Transcode bit of a block with an illegal sync header |

## Verification
The first bit of a block taken by an idle encoder is due on the outputs two edges after the accepting edge. Every later bit of the frame follows one clock after the one before it, and the parity follows the last data bit with no pause. The bench checks that latency once, at a fixed negative edge. Everything else is compared by order and not by cycle: the driver queues each frame's expected bits before it offers the blocks, and the monitor takes one entry whenever `tx_valid` is seen at a negative edge. Frame-start spacing is checked as a clock count of exactly 2112 between back-to-back frames. Stalls are checked as `tx_valid` at 0 well after the last queued bit should have drained.

// File: rtl/fec_pkg.sv
package fec_pkg;

   typedef enum logic {
      PH_DATA  = 1'b0,
      PH_CHECK = 1'b1
   } fec_phase_e;

   // A sync header is legal only when its two bits differ.
   function automatic logic hdr_illegal(input logic [1:0] hdr);
      return hdr[0] == hdr[1];
   endfunction

endpackage

// File: rtl/fec_transcoder.sv
module fec_transcoder #(
   parameter int unsigned PAYLOAD_W = 64
) (
   input  logic [PAYLOAD_W+1:0] blk,
   output logic [PAYLOAD_W:0]   word,
   output logic                 bad
);
   // Transcode bit sits at word[0] so it shifts out first.
   assign word = {blk[PAYLOAD_W+1:2], blk[1]};
   assign bad  = fec_pkg::hdr_illegal(blk[1:0]);
endmodule

// File: rtl/fec_parity_lfsr.sv
module fec_parity_lfsr #(
   parameter int unsigned     W    = 32,
   parameter logic [W-1:0]    POLY = 32'h00A0_0805
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   input  logic clear,
   input  logic drain,
   input  logic din,
   output logic msb
);
   logic [W-1:0] rem_q;
   logic [W-1:0] base;
   logic [W-1:0] rem_d;
   logic         fb;

   assign base = clear ? '0 : rem_q;
   assign fb   = (din ^ base[W-1]) & ~drain;

   genvar gi;
   generate
      for (gi = 0; gi < W; gi++) begin : g_tap
         if (gi == 0) begin : g_lsb
            assign rem_d[gi] = POLY[gi] & fb;
         end else if (POLY[gi]) begin : g_fb
            assign rem_d[gi] = base[gi-1] ^ fb;
         end else begin : g_pass
            assign rem_d[gi] = base[gi-1];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)    rem_q <= '0;
      else if (step) rem_q <= rem_d;
   end

   assign msb = rem_q[W-1];
endmodule

// File: rtl/fec_pn_scrambler.sv
module fec_pn_scrambler #(
   parameter int unsigned     LEN  = 58,
   parameter int unsigned     TAP  = 39,
   parameter logic [LEN-1:0]  SEED = 58'h3C3C3C3C3C3C3C3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   input  logic reseed,
   input  logic din,
   output logic dout
);
   logic [LEN-1:0] st_q;
   logic [LEN-1:0] base;
   logic           pn;

   assign base = reseed ? SEED : st_q;
   assign pn   = base[LEN-1] ^ base[TAP-1];
   assign dout = din ^ pn;

   always_ff @(posedge clk) begin
      if (!rst_n)    st_q <= SEED;
      else if (step) st_q <= {base[LEN-2:0], pn};
   end
endmodule

// File: rtl/fec_frame_encoder.sv
module fec_frame_encoder #(
   parameter int unsigned        BLOCKS    = 32,
   parameter int unsigned        PAYLOAD_W = 64,
   parameter int unsigned        PAR_W     = 32,
   parameter logic [PAR_W-1:0]   PAR_POLY  = 32'h00A0_0805,
   parameter int unsigned        PN_LEN    = 58,
   parameter int unsigned        PN_TAP    = 39,
   parameter logic [PN_LEN-1:0]  PN_SEED   = 58'h3C3C3C3C3C3C3C3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 blk_valid,
   output logic                 blk_ready,
   input  logic [PAYLOAD_W+1:0] blk_data,
   output logic                 tx_valid,
   output logic                 tx_bit,
   output logic                 tx_sof,
   output logic                 tx_hdr_err
);
   import fec_pkg::*;

   localparam int unsigned WORD_W     = PAYLOAD_W + 1;
   localparam int unsigned DATA_BITS  = BLOCKS * WORD_W;
   localparam int unsigned FRAME_BITS = DATA_BITS + PAR_W;
   localparam int unsigned POS_W      = $clog2(FRAME_BITS);
   localparam int unsigned J_W        = $clog2(WORD_W);
   localparam logic [POS_W-1:0] POS_LAST = POS_W'(FRAME_BITS - 1);
   localparam logic [POS_W-1:0] POS_DATA = POS_W'(DATA_BITS);
   localparam logic [J_W-1:0]   J_LAST   = J_W'(WORD_W - 1);

   generate
      if (BLOCKS * (PAYLOAD_W + 2) != FRAME_BITS) begin : g_bad_rate
         $error("parity width must equal block count to keep line rate");
      end
      if (PN_TAP == 0 || PN_TAP >= PN_LEN) begin : g_bad_tap
         $error("scrambler tap must lie inside the register");
      end
      if (PN_SEED == '0) begin : g_bad_seed
         $error("scrambler seed must be nonzero");
      end
      if (PAR_POLY[0] != 1'b1) begin : g_bad_poly
         $error("generator must have a constant term");
      end
   endgenerate

   // Transcoding
   logic [WORD_W-1:0] x_word;
   logic              x_bad;

   fec_transcoder #(.PAYLOAD_W(PAYLOAD_W)) u_xcode (
      .blk  (blk_data),
      .word (x_word),
      .bad  (x_bad)
   );

   // Frame sequencing state
   logic [POS_W-1:0]  pos_q;
   logic [J_W-1:0]    j_q;
   logic [WORD_W-1:0] cur_q;
   logic              cur_err_q;
   logic              cur_vld_q;

   fec_phase_e phase;
   logic       first_bit;
   logic       emit;
   logic       take;
   logic       raw_bit;
   logic       scr_bit;
   logic       par_msb;

   assign phase     = (pos_q < POS_DATA) ? PH_DATA : PH_CHECK;
   assign first_bit = (pos_q == '0);
   assign emit      = (phase == PH_DATA) ? cur_vld_q : 1'b1;
   assign blk_ready = ~cur_vld_q | ((phase == PH_DATA) & (j_q == J_LAST));
   assign take      = blk_valid & blk_ready;
   assign raw_bit   = (phase == PH_DATA) ? cur_q[0] : par_msb;

   fec_parity_lfsr #(.W(PAR_W), .POLY(PAR_POLY)) u_par (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (emit),
      .clear (first_bit),
      .drain (phase == PH_CHECK),
      .din   (raw_bit),
      .msb   (par_msb)
   );

   fec_pn_scrambler #(.LEN(PN_LEN), .TAP(PN_TAP), .SEED(PN_SEED)) u_scr (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (emit),
      .reseed (first_bit),
      .din    (raw_bit),
      .dout   (scr_bit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q <= '0;
      end else if (emit) begin
         pos_q <= (pos_q == POS_LAST) ? '0 : pos_q + POS_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         j_q       <= '0;
         cur_q     <= '0;
         cur_err_q <= 1'b0;
         cur_vld_q <= 1'b0;
      end else if (take) begin
         j_q       <= '0;
         cur_q     <= x_word;
         cur_err_q <= x_bad;
         cur_vld_q <= 1'b1;
      end else if (emit && phase == PH_DATA) begin
         cur_q <= cur_q >> 1;
         if (j_q == J_LAST) begin
            j_q       <= '0;
            cur_vld_q <= 1'b0;
         end else begin
            j_q <= j_q + J_W'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_valid   <= 1'b0;
         tx_bit     <= 1'b0;
         tx_sof     <= 1'b0;
         tx_hdr_err <= 1'b0;
      end else begin
         tx_valid   <= emit;
         tx_bit     <= emit & scr_bit;
         tx_sof     <= emit & first_bit;
         tx_hdr_err <= emit & (phase == PH_DATA) & (j_q == '0) & cur_err_q;
      end
   end
endmodule

// File: rtl/fec_frame_encoder_chk.sv
module fec_frame_encoder_chk #(
   parameter int unsigned BLOCKS = 32,
   parameter int unsigned WORD_W = 65,
   parameter int unsigned PAR_W  = 32
) (
   input logic clk,
   input logic rst_n,
   input logic tx_valid,
   input logic tx_sof,
   input logic tx_hdr_err
);
   localparam int unsigned DATA_BITS  = BLOCKS * WORD_W;
   localparam int unsigned FRAME_BITS = DATA_BITS + PAR_W;
   localparam int unsigned CNT_W      = $clog2(FRAME_BITS) + 1;

   // Bits seen since the last frame start.
   logic [CNT_W-1:0] vcnt;
   logic             seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vcnt <= '0;
         seen <= 1'b0;
      end else if (tx_valid) begin
         vcnt <= tx_sof ? CNT_W'(1) : vcnt + CNT_W'(1);
         seen <= 1'b1;
      end
   end

   assert_sof_has_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_sof |-> tx_valid);

   assert_sof_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_sof && seen) |-> (vcnt == CNT_W'(FRAME_BITS)));

   assert_sof_due_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && seen && vcnt == CNT_W'(FRAME_BITS)) |-> tx_sof);

   assert_parity_unbroken_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_sof && seen && vcnt >= CNT_W'(DATA_BITS - 1)
       && vcnt <= CNT_W'(FRAME_BITS - 2)) |=> tx_valid);

   assert_err_on_tbit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_hdr_err |-> (tx_valid && (tx_sof ||
         (vcnt < CNT_W'(DATA_BITS) && (vcnt % CNT_W'(WORD_W)) == '0))));
endmodule

bind fec_frame_encoder fec_frame_encoder_chk #(
   .BLOCKS (BLOCKS),
   .WORD_W (PAYLOAD_W + 1),
   .PAR_W  (PAR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tx_valid   (tx_valid),
   .tx_sof     (tx_sof),
   .tx_hdr_err (tx_hdr_err)
);

// File: tb/fec_frame_encoder_bench.sv
module fec_frame_encoder_bench;
   localparam int NB    = 32;
   localparam int WW    = 65;
   localparam int DBITS = NB * WW;
   localparam int FBITS = DBITS + 32;
   localparam logic [57:0] SEED = 58'h3C3C3C3C3C3C3C3;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        blk_valid;
   logic        blk_ready;
   logic [65:0] blk_data;
   logic        tx_valid, tx_bit, tx_sof, tx_hdr_err;

   always #10 clk = ~clk;

   fec_frame_encoder u_fec_frame_encoder (
      .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_ready(blk_ready),
      .blk_data(blk_data), .tx_valid(tx_valid), .tx_bit(tx_bit),
      .tx_sof(tx_sof), .tx_hdr_err(tx_hdr_err)
   );

   typedef struct {
      logic  b;
      logic  sof;
      logic  err;
      logic  cont;
      string req;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   failures = 0;
   int   cyc = 0;
   int   last_sof = -1;
   logic [31:0] lcg = 32'h1234_5678;

   logic dat  [0:FBITS-1];
   logic wrk  [0:FBITS-1];
   logic hist [0:FBITS+57];
   logic [65:0] fb [0:NB-1];

   function automatic logic [31:0] rnd();
      lcg = lcg * 32'd1103515245 + 32'd12345;
      return lcg;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   // Monitor: pops one expected bit per qualified output bit.
   always @(negedge clk) begin
      cyc++;
      if (rst_n && tx_valid) begin
         if (q.size() == 0) begin
            check(1'b0, "R9", "unexpected bit", 1, 0);
         end else begin
            exp_t e;
            e = q.pop_front();
            check(tx_sof === e.sof, "R7", "sof", int'(tx_sof), int'(e.sof));
            check(tx_hdr_err === e.err, "R8", "hdr_err", int'(tx_hdr_err), int'(e.err));
            check(tx_bit === e.b, e.req, "bit", int'(tx_bit), int'(e.b));
            if (tx_sof) begin
               if (e.cont)
                  check(cyc - last_sof == FBITS, "R6", "sof spacing",
                        cyc - last_sof, FBITS);
               last_sof = cyc;
            end
         end
      end
   end

   // kind 0: random legal; 1: illegal headers at blocks 3,17,31; 2: zero control
   task automatic build(input int kind);
      int degs [6] = '{32, 23, 21, 11, 2, 0};
      for (int b = 0; b < NB; b++) begin
         logic [1:0] h;
         logic [63:0] pl;
         pl = {rnd(), rnd()};
         h  = rnd()[7] ? 2'b10 : 2'b01;
         if (kind == 1 && b == 3)  h = 2'b00;
         if (kind == 1 && (b == 17 || b == 31)) h = 2'b11;
         if (kind == 2) begin h = 2'b01; pl = '0; end
         fb[b] = {pl, h};
         dat[b*WW] = h[1];
         for (int k = 0; k < 64; k++) dat[b*WW + 1 + k] = pl[k];
      end
      for (int i = 0; i < FBITS; i++) wrk[i] = (i < DBITS) ? dat[i] : 1'b0;
      for (int i = 0; i < DBITS; i++)
         if (wrk[i])
            for (int d = 0; d < 6; d++) wrk[i + 32 - degs[d]] ^= 1'b1;
      for (int i = DBITS; i < FBITS; i++) dat[i] = wrk[i];
      for (int k = 0; k < 58; k++) hist[57 - k] = SEED[k];
      for (int n = 0; n < FBITS; n++) hist[58 + n] = hist[n] ^ hist[n + 19];
   endtask

   task automatic push_frame(input bit cont);
      for (int i = 0; i < FBITS; i++) begin
         exp_t e;
         e.b    = dat[i] ^ hist[58 + i];
         e.sof  = (i == 0);
         e.cont = (i == 0) && cont;
         e.err  = 1'b0;
         if (i < DBITS && i % WW == 0)
            e.err = (fb[i / WW][0] == fb[i / WW][1]);
         e.req  = (i >= DBITS) ? "R4/R5" : ((i % WW == 0) ? "R2/R5" : "R3/R5");
         q.push_back(e);
      end
   endtask

   // Called at a negative edge; returns at the negative edge after acceptance.
   task automatic send(input logic [65:0] blk);
      logic r;
      blk_valid = 1'b1;
      blk_data  = blk;
      forever begin
         r = blk_ready;
         @(negedge clk);
         if (r) break;
      end
   endtask

   task automatic drive_frame(input int kind, input int gap_blk, input bit cont,
                              input bit lat_chk);
      build(kind);
      push_frame(cont);
      for (int b = 0; b < NB; b++) begin
         send(fb[b]);
         if (lat_chk && b == 0) begin
            check(tx_valid == 1'b0, "R10", "early bit", int'(tx_valid), 0);
            @(negedge clk);
            check(tx_sof == 1'b1 && tx_valid == 1'b1, "R10", "first bit latency",
                  int'(tx_sof), 1);
         end
         if (b == gap_blk) begin
            blk_valid = 1'b0;
            repeat (80) @(negedge clk);
            check(tx_valid == 1'b0, "R9", "stall valid", int'(tx_valid), 0);
            check(blk_ready == 1'b1, "R9", "stall ready", int'(blk_ready), 1);
         end
      end
   endtask

   initial begin
      rst_n     = 1'b0;
      blk_valid = 1'b0;
      blk_data  = '0;
      repeat (4) @(negedge clk);
      check(tx_valid == 0 && tx_sof == 0 && tx_hdr_err == 0, "R1", "outputs in reset",
            int'({tx_valid, tx_sof, tx_hdr_err}), 0);
      check(blk_ready == 1'b1, "R1", "ready in reset", int'(blk_ready), 1);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(tx_valid == 0 && blk_ready == 1, "R1", "idle after reset",
            int'({tx_valid, blk_ready}), 1);
      fork
         begin
            drive_frame(0, -1, 1'b0, 1'b1);
            drive_frame(0, -1, 1'b1, 1'b0);
            drive_frame(1, -1, 1'b1, 1'b0);
            drive_frame(2, 10, 1'b1, 1'b0);
            drive_frame(0, -1, 1'b0, 1'b0);
            blk_valid = 1'b0;
            for (int w = 0; w < 5000 && q.size() != 0; w++) @(negedge clk);
            repeat (5) @(negedge clk);
            check(q.size() == 0, "R9", "bits left undelivered", q.size(), 0);
            check(tx_valid == 1'b0, "R9", "idle after drain", int'(tx_valid), 0);
         end
         begin
            repeat (150000) @(posedge clk);
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", q.size(), 0);
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule